// File: doc/BRIEF.md
# Hoisted-Load Store-Conflict Tracker

This block lets a compiler move loads above earlier stores without proving that their addresses differ. When a hoisted load executes, it claims an entry in a small fully associative table. The entry holds the load's destination-register tag, its byte address and its access size. Every store that follows is compared against all live entries. Any entry whose byte range the store touches is dropped.

At the point where the load originally stood, the program issues a check carrying the same tag. One cycle later the block answers pass or fail. A pass means the early value is still good, and the entry is released. A fail tells the pipeline to reload, and if needed to branch to repair code. A missing entry always counts as a fail, so losing track of a load is never unsafe, only slower.

Access sizes are coded as a power of two: code 0 is one byte, 1 is two bytes, 2 is four bytes and 3 is eight bytes. An access covers the byte range from its address up to, but not including, the address plus its size. Addresses need not be aligned.

Top module: `spec_ld_tracker`

## Requirements
- R1: After reset no entry is live and `chk_done` is 0, so the first check of any tag answers fail.
- R2: A check with `chk_valid` high gives `chk_done` high exactly one cycle later. `chk_pass` is 1 when an entry with that tag was recorded by an earlier load and has not been dropped since.
- R3: A store whose byte range overlaps a live entry's byte range drops that entry, so a later check of its tag fails.
- R4: A store whose range only touches a live entry's range at its edges, without sharing any byte, leaves the entry alive.
- R5: Overlap is judged byte by byte across different sizes: a wide store covering a narrow load, or a narrow store hitting the last byte of a wide load, both drop the entry.
- R6: A check of a tag that has no live entry answers fail.
- R7: A passing check releases its entry, so an immediate second check of the same tag fails.
- R8: With all 8 entries live, a load with a new tag replaces the entry recorded longest ago. Checks of the evicted tag then fail, and checks of the other tags still pass.
- R9: A store in the same cycle as a load is not compared against the entry that load creates. The store still drops older overlapping entries.
- R10: A load whose tag already has a live entry overwrites that entry with its new address and size, and takes no other slot.
- R11: A check sees the table as it stood before the same cycle's store and load take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A hoisted load executes this cycle |
| ld_tag | input | TAG_W | Destination-register tag of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_size | input | 2 | Size code of the load (bytes = 2^code) |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | TAG_W | Tag being checked |
| chk_done | output | 1 | Check answer valid (one cycle after chk_valid) |
| chk_pass | output | 1 | 1 = early load value usable, 0 = reload needed |

## Verification
The assertions watch the timing and bookkeeping on every cycle. They check that each check is answered on the next cycle, that a missing tag never answers pass, and that at most one live entry carries a given tag. They also check that an allocation picks exactly one slot, that no eviction happens while a slot is free, and that a store-hit entry is gone on the next cycle. The bench's scenarios are what show the address arithmetic and the ordering: which byte ranges count as overlap at their edges and across sizes, which entry is oldest when the table fills, and how a store and a load in the same cycle interact.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  // One past the last byte of an access, widened so it cannot wrap.
  function automatic logic [64:0] span_end(input logic [63:0] base, input logic [1:0] sz);
    logic [64:0] len;
    len = 65'd1 << sz;
    return {1'b0, base} + len;
  endfunction

  // Two half-open byte ranges share at least one byte.
  function automatic logic spans_overlap(input logic [63:0] a, input logic [1:0] sa,
                                         input logic [63:0] b, input logic [1:0] sb);
    return ({1'b0, a} < span_end(b, sb)) && ({1'b0, b} < span_end(a, sa));
  endfunction

endpackage

// File: rtl/spec_ld_match.sv
module spec_ld_match
  import spec_ld_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 5,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
  input  logic [ENTRIES-1:0][1:0]        ent_size,
  input  logic                           st_valid,
  input  logic [ADDR_W-1:0]              st_addr,
  input  logic [1:0]                     st_size,
  input  logic [TAG_W-1:0]               ld_tag,
  input  logic [TAG_W-1:0]               chk_tag,
  output logic [ENTRIES-1:0]             st_hit,
  output logic [ENTRIES-1:0]             ld_tag_hit,
  output logic [ENTRIES-1:0]             chk_tag_hit
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign st_hit[i]      = st_valid && ent_valid[i] &&
                            spans_overlap(64'(ent_addr[i]), ent_size[i], 64'(st_addr), st_size);
    assign ld_tag_hit[i]  = ent_valid[i] && (ent_tag[i] == ld_tag);
    assign chk_tag_hit[i] = ent_valid[i] && (ent_tag[i] == chk_tag);
  end

endmodule

// File: rtl/spec_ld_alloc.sv
module spec_ld_alloc #(
  parameter int ENTRIES = 8,
  parameter int RANK_W  = 3
) (
  input  logic                           ld_valid,
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][RANK_W-1:0] ent_rank,
  input  logic [ENTRIES-1:0]             ld_tag_hit,
  output logic [ENTRIES-1:0]             alloc_vec,
  output logic                           evict
);

  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] free_pick;
  logic [ENTRIES-1:0] old_pick;
  logic               have_free;

  always_comb begin
    free_pick = '0;
    have_free = 1'b0;
    old_pick  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!ent_valid[i] && !have_free) begin
        free_pick[i] = 1'b1;
        have_free    = 1'b1;
      end
      if (ent_valid[i] && ent_rank[i] == OLDEST) old_pick[i] = 1'b1;
    end
  end

  always_comb begin
    alloc_vec = '0;
    evict     = 1'b0;
    if (ld_valid) begin
      if (|ld_tag_hit)    alloc_vec = ld_tag_hit;
      else if (have_free) alloc_vec = free_pick;
      else begin
        alloc_vec = old_pick;
        evict     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spec_ld_tracker.sv
module spec_ld_tracker
  import spec_ld_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 5,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              chk_done,
  output logic              chk_pass
);

  localparam int RANK_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0][1:0]        ent_size;
  logic [ENTRIES-1:0][RANK_W-1:0] ent_rank;

  // Named internal events
  logic [ENTRIES-1:0] st_hit, ld_tag_hit, chk_tag_hit;
  logic [ENTRIES-1:0] alloc_vec, kill_vec, free_vec, gone_vec;
  logic               evict;
  logic               chk_hit;

  spec_ld_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_match (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_addr(ent_addr), .ent_size(ent_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .ld_tag(ld_tag), .chk_tag(chk_tag),
    .st_hit(st_hit), .ld_tag_hit(ld_tag_hit), .chk_tag_hit(chk_tag_hit)
  );

  spec_ld_alloc #(.ENTRIES(ENTRIES), .RANK_W(RANK_W)) u_alloc (
    .ld_valid(ld_valid), .ent_valid(ent_valid), .ent_rank(ent_rank),
    .ld_tag_hit(ld_tag_hit), .alloc_vec(alloc_vec), .evict(evict)
  );

  assign chk_hit  = chk_valid && (|chk_tag_hit);
  assign kill_vec = st_hit & ~alloc_vec;                 // store skips the slot being filled
  assign free_vec = chk_valid ? chk_tag_hit : '0;
  assign gone_vec = ent_valid & (kill_vec | free_vec | alloc_vec);

  logic [ENTRIES-1:0]             nxt_valid;
  logic [ENTRIES-1:0][RANK_W-1:0] nxt_rank;

  // Rank 0 = newest; ranks of live entries stay distinct and dense.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      int dec;
      dec = 0;
      for (int j = 0; j < ENTRIES; j++)
        if (gone_vec[j] && ent_rank[j] < ent_rank[i]) dec++;
      nxt_valid[i] = ent_valid[i] && !gone_vec[i];
      nxt_rank[i]  = ent_rank[i] - RANK_W'(dec) + RANK_W'(ld_valid);
      if (alloc_vec[i]) begin
        nxt_valid[i] = 1'b1;
        nxt_rank[i]  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_rank  <= '0;
      ent_tag   <= '0;
      ent_addr  <= '0;
      ent_size  <= '0;
      chk_done  <= 1'b0;
      chk_pass  <= 1'b0;
    end else begin
      ent_valid <= nxt_valid;
      ent_rank  <= nxt_rank;
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_vec[i]) begin
          ent_tag[i]  <= ld_tag;
          ent_addr[i] <= ld_addr;
          ent_size[i] <= ld_size;
        end
      end
      chk_done <= chk_valid;
      chk_pass <= chk_hit;
    end
  end

  AST_CHECK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done); // R2
  AST_MISS_NEVER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !(|chk_tag_hit)) |=> !chk_pass); // R6
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_tag_hit)); // R10
  AST_ONE_SLOT_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $countones(alloc_vec) == 1); // R8
  AST_NO_EVICT_WITH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !(&ent_valid)) |-> !evict); // R8
  AST_DONE_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> !chk_done); // R1

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ast
    AST_STORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      kill_vec[k] |=> !ent_valid[k]); // R3
  end

endmodule

// File: tb/tb_spec_ld_tracker.sv
module tb_spec_ld_tracker;

  localparam int TAG_W  = 5;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
  logic [TAG_W-1:0]  ld_tag = '0, chk_tag = '0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
  logic [1:0]        ld_size = '0, st_size = '0;
  logic              chk_done, chk_pass;

  always #4 clk = ~clk;  // 125 MHz

  spec_ld_tracker #(.ENTRIES(8), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_tag(chk_tag),
    .chk_done(chk_done), .chk_pass(chk_pass)
  );

  int checks = 0;
  int failures = 0;
  bit exp_q[$];
  string req_q[$];

  task automatic note(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: answers arrive one cycle after the check
  always @(negedge clk) begin
    if (rst_n && chk_done) begin
      if (exp_q.size() == 0) note(1'b0, "R2_unexpected_done", 1, 0);
      else begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        note(chk_pass == e, r, int'(chk_pass), int'(e));
      end
    end
  end

  // Driver: one cycle of stimulus, any mix of load, store and check
  task automatic step(input bit lv, input int lt, input int la, input int ls,
                      input bit sv, input int sa, input int ss,
                      input bit cv, input int ct, input bit exp, input string req);
    @(negedge clk);
    ld_valid = lv; ld_tag = TAG_W'(lt); ld_addr = ADDR_W'(la); ld_size = 2'(ls);
    st_valid = sv; st_addr = ADDR_W'(sa); st_size = 2'(ss);
    chk_valid = cv; chk_tag = TAG_W'(ct);
    if (cv) begin exp_q.push_back(exp); req_q.push_back(req); end
    @(negedge clk);
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic load(input int t, input int a, input int s);
    step(1, t, a, s, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic store(input int a, input int s);
    step(0, 0, 0, 0, 1, a, s, 0, 0, 0, "");
  endtask
  task automatic check(input int t, input bit exp, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, t, exp, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    note(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(chk_done == 1'b0, "R1_done_low", int'(chk_done), 0);
    check(3, 0, "R1_empty_after_reset");

    load(1, 'h100, 2);                    check(1, 1, "R2_load_then_check");

    load(2, 'h200, 2); store('h203, 0);  check(2, 0, "R3_overlap_drops");

    load(3, 'h300, 2); store('h304, 0); store('h2FC, 2);
    check(3, 1, "R4_edge_touch_keeps");

    load(4, 'h405, 0); store('h400, 3);  check(4, 0, "R5_wide_store_covers_byte");
    load(5, 'h500, 3); store('h507, 1);  check(5, 0, "R5_half_hits_last_byte");

    check(9, 0, "R6_unknown_tag");

    load(6, 'h600, 2); check(6, 1, "R7_first_check");
    check(6, 0, "R7_second_check");

    for (int t = 10; t < 18; t++) load(t, 'h1000 + t * 16, 2);
    load(18, 'h2000, 2);
    check(10, 0, "R8_oldest_evicted");
    for (int t = 11; t < 19; t++) check(t, 1, "R8_survivor");

    step(1, 20, 'h800, 2, 1, 'h800, 2, 0, 0, 0, "");
    check(20, 1, "R9_same_cycle_store_skips_new");
    load(21, 'h900, 2);
    step(1, 22, 'h900, 2, 1, 'h900, 2, 0, 0, 0, "");
    check(21, 0, "R9_older_entry_dropped");
    check(22, 1, "R9_new_entry_kept");

    load(23, 'hA00, 2); load(23, 'hB00, 2); store('hA00, 2);
    check(23, 1, "R10_tag_overwritten");

    load(24, 'hC00, 2);
    step(0, 0, 0, 0, 1, 'hC00, 2, 1, 24, 1, "R11_check_sees_prior_state");

    repeat (3) @(negedge clk);
    note(exp_q.size() == 0, "R2_all_answered", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule